// File: doc/BRIEF.md
# Line-Buffered 5x5 Convolution Engine

This block runs a 5x5 valid convolution over one 28x28 image of signed 12-bit pixels with three kernels and produces three 24x24 feature maps. Pixels are fetched one at a time from an external image memory through a read-enable/read-address port. That memory returns the word one clock after the read enable. A 140-entry register window holds five image rows. For each window position, one 25-tap multiply-accumulate produces a result. The result goes out as an address/data/enable write, one word per clock.

A frame starts when the start input falls while the engine is idle. The engine first loads five rows. It then walks the kernels in order over the current row window: 24 outputs for kernel 0, then kernel 1, then kernel 2. After that it brings in the next image row by moving every buffered column up one row and placing the new pixel at the bottom. The final write of the frame is followed by a one-cycle done pulse. Kernel weights and biases are static parallel inputs.

Top module: `conv5_engine`

## Requirements
- R1: A frame starts only on a falling edge of `start_n`, seen through a two-flop synchroniser while the engine is idle. With `start_n` held high, the engine stays idle and issues no reads.
- R2: The initial load issues reads to image addresses 0 to 139, one per clock. The word returned one clock later is stored in window entry equal to its read address.
- R3: No output is written before all 140 pixels of the first five rows have been requested.
- R4: For every output row, kernel 0, kernel 1 and kernel 2 each write 24 results in turn, in increasing column order. The kernel changes after column 23.
- R5: After kernel 2 finishes an output row (except the last one), the engine reads the 28 pixels of the next image row. It then resumes computing once its read enable has fallen. Reads and writes are never active in the same cycle.
- R6: The write address equals kernel*576 + 24*row + column. It is always below 1728.
- R7: Each written word is the 25-product sum at full precision plus the kernel's sign-extended 8-bit bias. This value is shifted right arithmetically by `SHIFT` (rounding toward minus infinity) and clipped to the signed 12-bit range. Tap i*5+j of kernel k sits at bits (k*25+i*5+j)*8 of `kern_w`. Kernel k's bias sits at bits k*8 of `kern_b`.
- R8: `done` is high for exactly one clock, in the cycle after the final write of a frame. The engine is then idle.
- R9: A falling edge on `start_n` while a frame is in progress has no effect on the reads or writes of that frame.
- R10: During and after a synchronous active-high reset, `img_ren`, `out_we` and `done` are low.
- R11: Within a frame, consecutive enabled reads step the address by exactly one. A frame makes 784 reads covering 0 to 783.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_n | input | 1 | Start request; a falling edge starts a frame |
| img_ren | output | 1 | Image memory read enable |
| img_raddr | output | 10 | Image memory read address |
| img_rdata | input | 12 | Pixel returned one clock after the read enable |
| kern_w | input | 600 | Three kernels of 25 signed 8-bit weights |
| kern_b | input | 24 | Three signed 8-bit biases |
| out_we | output | 1 | Result write enable |
| out_waddr | output | 11 | Result write address |
| out_wdata | output | 12 | Signed 12-bit result |
| done | output | 1 | One-cycle pulse after the final write |

## Verification
The bench keeps the default image and kernel sizes but builds the engine with `SHIFT` set to 9 rather than 7. With that setting, random pixels and weights give a spread of results where only the tails reach the clip limits, so both the plain shift path and the clipping are exercised in one random frame. A second frame uses constant extreme pixels and weights of either sign to drive both clip limits. That frame also uses a zero-weight kernel with a negative bias, which shows that the shift rounds toward minus infinity.

// File: rtl/conv5_pkg.sv
package conv5_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_CALC = 2'd2
  } phase_e;

endpackage

// File: rtl/conv5_ctrl.sv
module conv5_ctrl
  import conv5_pkg::*;
#(
  parameter int IMG_W = 28,
  parameter int IMG_H = 28,
  parameter int K     = 5,
  parameter int NKER  = 3,
  localparam int OW     = IMG_W - K + 1,
  localparam int OH     = IMG_H - K + 1,
  localparam int FILL_N = K * IMG_W,
  localparam int MAP    = OW * OH,
  localparam int NPIX   = IMG_W * IMG_H,
  localparam int RA_W   = $clog2(NPIX + 1),
  localparam int WA_W   = $clog2(NKER * MAP),
  localparam int CNT_W  = $clog2(FILL_N + 1),
  localparam int C_W    = $clog2(OW),
  localparam int R_W    = $clog2(OH),
  localparam int KS_W   = (NKER > 1) ? $clog2(NKER) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_n,
  output logic            img_ren,
  output logic [RA_W-1:0] img_raddr,
  output logic            buf_we,
  output logic [CNT_W-1:0] buf_idx,
  output logic            buf_shift,
  output logic            calc_go,
  output logic [KS_W-1:0] kern,
  output logic [C_W-1:0]  col,
  output logic [WA_W-1:0] calc_addr,
  output logic            done
);

  phase_e           phase;
  logic             st1, st2;
  logic             ren_q, vld_q, refill, fin_q, done_q;
  logic [RA_W-1:0]  raddr_q, rd_ptr;
  logic [CNT_W-1:0] idx_q, tag_q, icnt;
  logic [R_W-1:0]   orow;
  logic             start_fall;

  assign start_fall = st2 & ~st1;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= ST_IDLE;
      st1     <= 1'b1;
      st2     <= 1'b1;
      ren_q   <= 1'b0;
      vld_q   <= 1'b0;
      raddr_q <= '0;
      idx_q   <= '0;
      tag_q   <= '0;
      icnt    <= '0;
      rd_ptr  <= '0;
      refill  <= 1'b0;
      kern    <= '0;
      col     <= '0;
      orow    <= '0;
      fin_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st1    <= start_n;
      st2    <= st1;
      vld_q  <= ren_q;
      tag_q  <= idx_q;
      done_q <= fin_q;
      fin_q  <= 1'b0;
      ren_q  <= 1'b0;
      unique case (phase)
        ST_IDLE: begin
          if (start_fall) begin
            phase  <= ST_FILL;
            icnt   <= '0;
            rd_ptr <= '0;
          end
        end
        ST_FILL: begin
          if (icnt < CNT_W'(FILL_N)) begin
            ren_q   <= 1'b1;
            raddr_q <= rd_ptr;
            idx_q   <= icnt;
            icnt    <= icnt + 1'b1;
            rd_ptr  <= rd_ptr + 1'b1;
          end
          if (vld_q && tag_q == CNT_W'(FILL_N - 1)) begin
            phase  <= ST_CALC;
            refill <= 1'b0;
            kern   <= '0;
            col    <= '0;
            orow   <= '0;
          end
        end
        ST_CALC: begin
          if (refill) begin
            if (icnt < CNT_W'(IMG_W)) begin
              ren_q   <= 1'b1;
              raddr_q <= rd_ptr;
              idx_q   <= icnt;
              icnt    <= icnt + 1'b1;
              rd_ptr  <= rd_ptr + 1'b1;
            end
            if (vld_q && tag_q == CNT_W'(IMG_W - 1)) refill <= 1'b0;
          end else if (col == C_W'(OW - 1)) begin
            col <= '0;
            if (kern == KS_W'(NKER - 1)) begin
              kern <= '0;
              if (orow == R_W'(OH - 1)) begin
                phase <= ST_IDLE;
                fin_q <= 1'b1;
              end else begin
                orow   <= orow + 1'b1;
                refill <= 1'b1;
                icnt   <= '0;
              end
            end else begin
              kern <= kern + 1'b1;
            end
          end else begin
            col <= col + 1'b1;
          end
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end

  assign img_ren   = ren_q;
  assign img_raddr = raddr_q;
  assign buf_we    = vld_q;
  assign buf_idx   = tag_q;
  assign buf_shift = (phase == ST_CALC);
  assign calc_go   = (phase == ST_CALC) && !refill;
  assign calc_addr = WA_W'(kern) * WA_W'(MAP) + WA_W'(orow) * WA_W'(OW) + WA_W'(col);
  assign done      = done_q;

endmodule

// File: rtl/conv5_window.sv
module conv5_window #(
  parameter int IMG_W = 28,
  parameter int K     = 5,
  parameter int PIX_W = 12,
  parameter int CNT_W = 8,
  parameter int C_W   = 5,
  localparam int FILL_N = K * IMG_W
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic                   shift,
  input  logic [CNT_W-1:0]       idx,
  input  logic [PIX_W-1:0]       wdata,
  input  logic [C_W-1:0]         col,
  output logic [K*K*PIX_W-1:0]   taps
);

  logic [PIX_W-1:0] win [FILL_N];

  // fill: entry = read index; refill: column moves up one row, new pixel at bottom
  always_ff @(posedge clk) begin
    if (we) begin
      if (!shift) begin
        win[int'(idx)] <= wdata;
      end else begin
        for (int r = 0; r < K - 1; r++)
          win[r * IMG_W + int'(idx)] <= win[(r + 1) * IMG_W + int'(idx)];
        win[(K - 1) * IMG_W + int'(idx)] <= wdata;
      end
    end
  end

  for (genvar i = 0; i < K; i++) begin : g_row
    for (genvar j = 0; j < K; j++) begin : g_col
      assign taps[(i * K + j) * PIX_W +: PIX_W] = win[i * IMG_W + j + int'(col)];
    end
  end

endmodule

// File: rtl/conv5_mac.sv
module conv5_mac #(
  parameter int K     = 5,
  parameter int NKER  = 3,
  parameter int PIX_W = 12,
  parameter int W_W   = 8,
  parameter int B_W   = 8,
  parameter int OUT_W = 12,
  parameter int SHIFT = 7,
  parameter int WA_W  = 11,
  parameter int KS_W  = 2,
  localparam int KK     = K * K,
  localparam int PROD_W = PIX_W + W_W,
  localparam int ACC_W  = PROD_W + $clog2(KK) + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  go,
  input  logic [KS_W-1:0]       kern,
  input  logic [WA_W-1:0]       addr,
  input  logic [KK*PIX_W-1:0]   taps,
  input  logic [NKER*KK*W_W-1:0] weights,
  input  logic [NKER*B_W-1:0]   biases,
  output logic                  we_q,
  output logic [WA_W-1:0]       addr_q,
  output logic [OUT_W-1:0]      data_q
);

  localparam logic signed [ACC_W-1:0] SAT_HI = {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SAT_LO = {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [PIX_W-1:0]  px;
  logic signed [W_W-1:0]    wt;
  logic signed [B_W-1:0]    bs;
  logic signed [PROD_W-1:0] pr;
  logic signed [ACC_W-1:0]  acc, sh;
  logic [OUT_W-1:0]         clipped;

  always_comb begin
    acc = '0;
    px  = '0;
    wt  = '0;
    pr  = '0;
    for (int t = 0; t < KK; t++) begin
      px  = taps[t * PIX_W +: PIX_W];
      wt  = weights[(int'(kern) * KK + t) * W_W +: W_W];
      pr  = PROD_W'(px) * PROD_W'(wt);
      acc = acc + ACC_W'(pr);
    end
    bs  = biases[int'(kern) * B_W +: B_W];
    acc = acc + ACC_W'(bs);
    sh  = acc >>> SHIFT;
    if (sh > SAT_HI)      clipped = SAT_HI[OUT_W-1:0];
    else if (sh < SAT_LO) clipped = SAT_LO[OUT_W-1:0];
    else                  clipped = sh[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      we_q <= go;
      if (go) begin
        addr_q <= addr;
        data_q <= clipped;
      end
    end
  end

endmodule

// File: rtl/conv5_engine.sv
module conv5_engine #(
  parameter int IMG_W = 28,
  parameter int IMG_H = 28,
  parameter int K     = 5,
  parameter int NKER  = 3,
  parameter int PIX_W = 12,
  parameter int W_W   = 8,
  parameter int B_W   = 8,
  parameter int OUT_W = 12,
  parameter int SHIFT = 7,
  localparam int OW     = IMG_W - K + 1,
  localparam int OH     = IMG_H - K + 1,
  localparam int FILL_N = K * IMG_W,
  localparam int NPIX   = IMG_W * IMG_H,
  localparam int RA_W   = $clog2(NPIX + 1),
  localparam int WA_W   = $clog2(NKER * OW * OH),
  localparam int CNT_W  = $clog2(FILL_N + 1),
  localparam int C_W    = $clog2(OW),
  localparam int KS_W   = (NKER > 1) ? $clog2(NKER) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_n,
  output logic                     img_ren,
  output logic [RA_W-1:0]          img_raddr,
  input  logic [PIX_W-1:0]         img_rdata,
  input  logic [NKER*K*K*W_W-1:0]  kern_w,
  input  logic [NKER*B_W-1:0]      kern_b,
  output logic                     out_we,
  output logic [WA_W-1:0]          out_waddr,
  output logic [OUT_W-1:0]         out_wdata,
  output logic                     done
);

  logic             buf_we, buf_shift, calc_go;
  logic [CNT_W-1:0] buf_idx;
  logic [KS_W-1:0]  kern;
  logic [C_W-1:0]   col;
  logic [WA_W-1:0]  calc_addr;
  logic [K*K*PIX_W-1:0] taps;

  conv5_ctrl #(.IMG_W(IMG_W), .IMG_H(IMG_H), .K(K), .NKER(NKER)) u_ctrl (
    .clk(clk), .rst(rst), .start_n(start_n),
    .img_ren(img_ren), .img_raddr(img_raddr),
    .buf_we(buf_we), .buf_idx(buf_idx), .buf_shift(buf_shift),
    .calc_go(calc_go), .kern(kern), .col(col), .calc_addr(calc_addr),
    .done(done)
  );

  conv5_window #(.IMG_W(IMG_W), .K(K), .PIX_W(PIX_W), .CNT_W(CNT_W), .C_W(C_W)) u_win (
    .clk(clk), .we(buf_we), .shift(buf_shift), .idx(buf_idx),
    .wdata(img_rdata), .col(col), .taps(taps)
  );

  conv5_mac #(.K(K), .NKER(NKER), .PIX_W(PIX_W), .W_W(W_W), .B_W(B_W),
              .OUT_W(OUT_W), .SHIFT(SHIFT), .WA_W(WA_W), .KS_W(KS_W)) u_mac (
    .clk(clk), .rst(rst), .go(calc_go), .kern(kern), .addr(calc_addr),
    .taps(taps), .weights(kern_w), .biases(kern_b),
    .we_q(out_we), .addr_q(out_waddr), .data_q(out_wdata)
  );

endmodule

// File: rtl/conv5_engine_chk.sv
module conv5_engine_chk #(
  parameter int RA_W  = 10,
  parameter int WA_W  = 11,
  parameter int NPIX  = 784,
  parameter int TOTAL = 1728,
  parameter int OW    = 24
) (
  input logic            clk,
  input logic            rst,
  input logic            img_ren,
  input logic [RA_W-1:0] img_raddr,
  input logic            out_we,
  input logic [WA_W-1:0] out_waddr,
  input logic            done
);

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_done_after_write: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(out_we));

  a_r6_addr_in_range: assert property (@(posedge clk) disable iff (rst)
    out_we |-> (int'(out_waddr) < TOTAL));

  a_r4_column_run: assert property (@(posedge clk) disable iff (rst)
    (out_we && $past(out_we) && (int'(out_waddr) % OW != 0))
      |-> out_waddr == $past(out_waddr) + 1'b1);

  a_r11_read_step: assert property (@(posedge clk) disable iff (rst)
    (img_ren && $past(img_ren)) |-> img_raddr == $past(img_raddr) + 1'b1);

  a_r11_read_bound: assert property (@(posedge clk) disable iff (rst)
    img_ren |-> (int'(img_raddr) < NPIX));

  a_r5_read_write_apart: assert property (@(posedge clk) disable iff (rst)
    !(img_ren && out_we));

endmodule

bind conv5_engine conv5_engine_chk #(
  .RA_W(RA_W), .WA_W(WA_W), .NPIX(NPIX), .TOTAL(NKER * OW * OH), .OW(OW)
) u_chk (
  .clk(clk), .rst(rst), .img_ren(img_ren), .img_raddr(img_raddr),
  .out_we(out_we), .out_waddr(out_waddr), .done(done)
);

// File: tb/test_conv5_engine.sv
`timescale 1ns/1ps
module test_conv5_engine;

  localparam int IW = 28, IH = 28, KS = 5, NK = 3, SH = 9;
  localparam int OWD = IW - KS + 1, OHD = IH - KS + 1;
  localparam int NPX = IW * IH, FILL = KS * IW, TOT = NK * OWD * OHD;

  logic clk = 1'b0, rst = 1'b1, start_n = 1'b1;
  logic img_ren;
  logic [9:0]  img_raddr;
  logic [11:0] img_rdata = '0;
  logic [NK*KS*KS*8-1:0] kern_w = '0;
  logic [NK*8-1:0] kern_b = '0;
  logic out_we, done;
  logic [10:0] out_waddr;
  logic [11:0] out_wdata;

  always #5 clk = ~clk;

  conv5_engine #(.SHIFT(SH)) i_conv5_engine (
    .clk(clk), .rst(rst), .start_n(start_n), .img_ren(img_ren),
    .img_raddr(img_raddr), .img_rdata(img_rdata), .kern_w(kern_w),
    .kern_b(kern_b), .out_we(out_we), .out_waddr(out_waddr),
    .out_wdata(out_wdata), .done(done)
  );

  logic [11:0] imem [NPX];
  int img [NPX];
  int wgt [NK][KS*KS];
  int bia [NK];
  int exp_a[$], exp_d[$];
  int ntests = 0, nfail = 0;
  int rd_exp = 0, rd_seen = 0, done_cnt = 0;
  bit prev_we = 1'b0, monitor_on = 1'b0;

  always @(posedge clk) if (img_ren) img_rdata <= imem[img_raddr];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // reference model: per output row, kernels in order, columns ascending
  task automatic build_expect();
    exp_a.delete();
    exp_d.delete();
    for (int r = 0; r < OHD; r++)
      for (int k = 0; k < NK; k++)
        for (int c = 0; c < OWD; c++) begin
          int acc, v;
          acc = bia[k];
          for (int i = 0; i < KS; i++)
            for (int j = 0; j < KS; j++)
              acc += img[(r + i) * IW + c + j] * wgt[k][i * KS + j];
          v = acc >>> SH;
          if (v > 2047) v = 2047;
          if (v < -2048) v = -2048;
          exp_a.push_back(k * OWD * OHD + r * OWD + c);
          exp_d.push_back(v);
        end
  endtask

  task automatic load_ports();
    for (int p = 0; p < NPX; p++) imem[p] = 12'(img[p]);
    for (int k = 0; k < NK; k++) begin
      kern_b[k*8 +: 8] = 8'(bia[k]);
      for (int t = 0; t < KS*KS; t++) kern_w[(k*KS*KS + t)*8 +: 8] = 8'(wgt[k][t]);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && monitor_on) begin
      if (img_ren) begin
        check(int'(img_raddr) == rd_exp, (rd_exp < FILL) ? "R2 read addr" : "R5/R11 read addr",
              int'(img_raddr), rd_exp);
        rd_exp++;
        rd_seen++;
      end
      if (out_we) begin
        if (exp_a.size() == 0) begin
          check(1'b0, "R4 extra write", int'(out_waddr), -1);
        end else begin
          int ea, ed;
          ea = exp_a.pop_front();
          ed = exp_d.pop_front();
          if (exp_a.size() == TOT - 1)
            check(rd_seen >= FILL, "R3 write before window full", rd_seen, FILL);
          check(int'(out_waddr) == ea, "R6 write addr", int'(out_waddr), ea);
          check(int'($signed(out_wdata)) == ed, "R7 write data", int'($signed(out_wdata)), ed);
        end
      end
      if (done) begin
        done_cnt++;
        check(prev_we && exp_a.size() == 0, "R8 done after final write", exp_a.size(), 0);
      end
      prev_we = out_we;
    end
  end

  task automatic kick();
    @(negedge clk) start_n = 1'b0;
    repeat (2) @(negedge clk);
    start_n = 1'b1;
  endtask

  task automatic run_frame(input bit poke_busy);
    int cyc, seen;
    build_expect();
    load_ports();
    rd_exp = 0;
    rd_seen = 0;
    done_cnt = 0;
    // R1: held high, engine stays idle
    seen = rd_seen;
    repeat (20) @(negedge clk);
    check(rd_seen == seen, "R1 idle without start edge", rd_seen, seen);
    kick();
    cyc = 0;
    while (done_cnt == 0 && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (poke_busy && cyc == 600) begin
        start_n = 1'b0;  // R9: edge while busy
        @(negedge clk);
        @(negedge clk);
        start_n = 1'b1;
        cyc += 2;
      end
    end
    check(done_cnt == 1, "R8 watchdog/done seen", done_cnt, 1);
    check(rd_seen == NPX, "R11 total reads", rd_seen, NPX);
    check(exp_a.size() == 0, "R4 all writes seen", exp_a.size(), 0);
    // after done: stays idle, no second frame from the ignored edge (R9)
    seen = rd_seen;
    repeat (40) @(negedge clk);
    check(rd_seen == seen, "R9 no restart after ignored edge", rd_seen, seen);
    check(done_cnt == 1, "R8 single done pulse", done_cnt, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!img_ren && !out_we && !done, "R10 outputs low in reset",
          int'({img_ren, out_we, done}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!img_ren && !out_we && !done, "R10 outputs low after reset",
          int'({img_ren, out_we, done}), 0);
    monitor_on = 1'b1;

    // frame 1: random data, busy start edge injected
    for (int p = 0; p < NPX; p++) img[p] = int'($urandom_range(4095)) - 2048;
    for (int k = 0; k < NK; k++) begin
      bia[k] = int'($urandom_range(255)) - 128;
      for (int t = 0; t < KS*KS; t++) wgt[k][t] = int'($urandom_range(255)) - 128;
    end
    run_frame(1'b1);

    // frame 2: clip limits and floor of the shift (R7)
    for (int p = 0; p < NPX; p++) img[p] = 2047;
    for (int t = 0; t < KS*KS; t++) begin
      wgt[0][t] = 127;
      wgt[1][t] = -128;
      wgt[2][t] = 0;
    end
    bia[0] = 5;
    bia[1] = -7;
    bia[2] = -128;
    run_frame(1'b0);

    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

endmodule